// File: doc/BRIEF.md
# Sixteen-bit Timer with Compare Channels and Input Capture

This peripheral holds a 16-bit counter that advances one step for each timer tick. Software picks where ticks come from. They can come from an internal divider that fires once every `PRESCALE_DIV` system clocks, or from the rising or falling edges of an external clock pin. When no source is chosen, the counter holds its value. The count wraps to zero after it reaches TOP. TOP is the all-ones value, the active value of compare channel A, or the value held in the capture register.

Two compare channels each keep a software-written buffer and an active value. In normal mode a write reaches the active value at once. In PWM mode the buffer moves into the active value on the tick that wraps the counter. A channel's output pin can toggle on every match, or run single-slope PWM: it goes high on the wrap and low on the match.

The capture register takes a copy of the count on a chosen edge of either the capture pin or the comparator input. An optional four-sample glitch filter can sit in that path. Four flags record events, each cleared by writing a one to it. Each interrupt line is a flag masked by its own enable bit.

Top module: `timer_cc`

## Requirements
- R1: After reset every register reads zero, both output pins are low and every interrupt line is low.
- R2: Control B bits [1:0] choose the tick source. 0 holds the count. 1 gives one tick every `PRESCALE_DIV` (default 8) clocks. 2 ticks on rising edges of `extClk` and 3 on its falling edges.
- R3: On a tick with the count equal to TOP, the count becomes zero and flag bit 0 is set. Control A bits [5:4] choose TOP: 0 gives 0xFFFF, 1 gives the active compare A value and 2 gives the capture register.
- R4: A tick with the count equal to a channel's active compare value sets flag bit 1 for channel A and flag bit 2 for channel B.
- R5: With control A bit 6 (PWM) clear, a compare write takes effect at once. With it set, the write only fills the buffer, which becomes active on the wrapping tick. Reads of the compare addresses return the buffer.
- R6: Output mode 1 (control A bits [1:0] for A, [3:2] for B) inverts the channel's pin on every match.
- R7: Output mode 2 with PWM set drives the pin high on the wrapping tick and low on a match, with the wrap taking priority. When TOP comes from compare A, pin A stays low.
- R8: A capture event copies the count into the capture register and sets flag bit 3. Control B bit 2 chooses the edge (1 rising, 0 falling) and bit 3 chooses the source (0 `capPin`, 1 `compIn`). Edges on the unselected input have no effect.
- R9: With control B bit 4 set, the capture input must hold a level for four consecutive clocks before it counts, so a two-clock pulse is ignored. With the bit clear, the same pulse captures.
- R10: Writing to the flag address clears each flag whose data bit is 1 and leaves the others. `irq[i]` is flag i AND mask bit i.
- R11: A write to the count address loads the counter and takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address: 0 ctrlA, 1 ctrlB, 2 count, 3 cmpA, 4 cmpB, 5 capture, 6 flags, 7 mask |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read address, same map as writes |
| rdData | output | 16 | Read data, combinational |
| extClk | input | 1 | External count clock, asynchronous |
| capPin | input | 1 | Capture pin, asynchronous |
| compIn | input | 1 | Comparator result used as alternate capture source |
| outA | output | 1 | Waveform output of channel A |
| outB | output | 1 | Waveform output of channel B |
| irq | output | 4 | Masked interrupt lines: overflow, match A, match B, capture |

## Verification
The bench loads a new compare A value in PWM mode and checks that the match flag still fires at the old value until the wrap. A design that updated the active value at once would miss that flag and clear pin A early. It also moves TOP between 0xFFFF, compare A and the capture register, and checks the count after the wrap. A wrong TOP mux would leave the count at a non-zero value. Capture is driven from the unselected input and with the wrong edge polarity, and a design that leaked either would overwrite the captured count. A two-clock glitch is sent with the filter on and again with it off, so a missing filter or a filter that is always on would show in the capture register.

// File: rtl/timer_cc_pkg.sv
package timer_cc_pkg;
  localparam int NUM_CH = 2;
  localparam int FLAG_W = NUM_CH + 2;

  typedef enum logic [1:0] {
    CLK_OFF      = 2'd0,
    CLK_INT      = 2'd1,
    CLK_EXT_RISE = 2'd2,
    CLK_EXT_FALL = 2'd3
  } clkSel_e;

  typedef enum logic [1:0] {
    TOP_MAX  = 2'd0,
    TOP_CMPA = 2'd1,
    TOP_CAP  = 2'd2,
    TOP_RSV  = 2'd3
  } topSel_e;

  localparam logic [2:0] ADDR_CTRLA = 3'd0;
  localparam logic [2:0] ADDR_CTRLB = 3'd1;
  localparam logic [2:0] ADDR_CNT   = 3'd2;
  localparam logic [2:0] ADDR_CMP0  = 3'd3;
  localparam logic [2:0] ADDR_CAP   = 3'd5;
  localparam logic [2:0] ADDR_FLAGS = 3'd6;
  localparam logic [2:0] ADDR_MASK  = 3'd7;

  typedef struct packed {
    logic tick;
    logic capture;
  } tmrStrobe_t;
endpackage

// File: rtl/timer_cc_ctrl.sv
module timer_cc_ctrl
  import timer_cc_pkg::*;
#(
  parameter int PRESCALE_DIV = 8,
  parameter int FILT_LEN     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  clkSel_e    clkSel,
  input  logic       capRise,
  input  logic       capSrc,
  input  logic       capFilt,
  input  logic       extClk,
  input  logic       capPin,
  input  logic       compIn,
  output tmrStrobe_t strobe
);
  localparam int PRE_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

  logic [PRE_W-1:0]    preCnt;
  logic [1:0]          extSync, pinSync, cmpSync;
  logic                extPrev, filtLvl, capPrev;
  logic [FILT_LEN-1:0] capHist;
  logic                selLvl, capLvl, intTick, extRise, extFall;

  always_comb begin
    intTick = (clkSel == CLK_INT) && (preCnt == PRE_LAST);
    extRise = extSync[1] & ~extPrev;
    extFall = ~extSync[1] & extPrev;
    selLvl  = capSrc ? cmpSync[1] : pinSync[1];
    capLvl  = capFilt ? filtLvl : selLvl;
    case (clkSel)
      CLK_INT:      strobe.tick = intTick;
      CLK_EXT_RISE: strobe.tick = extRise;
      CLK_EXT_FALL: strobe.tick = extFall;
      default:      strobe.tick = 1'b0;
    endcase
    strobe.capture = capRise ? (capLvl & ~capPrev) : (~capLvl & capPrev);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      extSync <= '0;
      pinSync <= '0;
      cmpSync <= '0;
      extPrev <= 1'b0;
      capHist <= '0;
      filtLvl <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      extSync <= {extSync[0], extClk};
      pinSync <= {pinSync[0], capPin};
      cmpSync <= {cmpSync[0], compIn};
      extPrev <= extSync[1];
      capHist <= {capHist[FILT_LEN-2:0], selLvl};
      if (&capHist)       filtLvl <= 1'b1;
      else if (~|capHist) filtLvl <= 1'b0;
      capPrev <= capLvl;
      if (clkSel != CLK_INT || preCnt == PRE_LAST) preCnt <= '0;
      else                                          preCnt <= preCnt + 1'b1;
    end
  end

  assert_off_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (clkSel == CLK_OFF) |-> !strobe.tick);
  assert_int_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (clkSel == CLK_INT && strobe.tick) |=> !strobe.tick);
endmodule

// File: rtl/timer_cc_dp.sv
module timer_cc_dp
  import timer_cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobe_t        strobe,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [2:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] outVec,
  output logic [FLAG_W-1:0] irq,
  output clkSel_e           clkSel,
  output logic              capRise,
  output logic              capSrc,
  output logic              capFilt
);
  logic [7:0]                   ctrlA, ctrlB;
  logic [CNT_W-1:0]             cnt, capReg, topVal;
  logic [FLAG_W-1:0]            flags, mask, setVec, clrVec;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpActVec, cmpBufVec;
  logic [NUM_CH-1:0]            matchEv;
  logic                         pwmMode, atTop, wrapEv, cntWr, capWr;
  topSel_e                      topSel;

  assign clkSel  = clkSel_e'(ctrlB[1:0]);
  assign capRise = ctrlB[2];
  assign capSrc  = ctrlB[3];
  assign capFilt = ctrlB[4];
  assign topSel  = topSel_e'(ctrlA[5:4]);
  assign pwmMode = ctrlA[6];
  assign cntWr   = wrEn && (wrAddr == ADDR_CNT);
  assign capWr   = wrEn && (wrAddr == ADDR_CAP);

  always_comb begin
    case (topSel)
      TOP_CMPA: topVal = cmpActVec[0];
      TOP_CAP:  topVal = capReg;
      default:  topVal = '1;
    endcase
    atTop  = (cnt == topVal);
    wrapEv = strobe.tick && atTop;
    setVec = {strobe.capture, matchEv, wrapEv};
    clrVec = (wrEn && wrAddr == ADDR_FLAGS) ? wrData[FLAG_W-1:0] : '0;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] bufQ, actQ;
    logic             outQ, blocked;
    logic [1:0]       outMode;
    logic             chWr;
    assign outMode = ctrlA[2*ch+1 -: 2];
    assign blocked = (ch == 0) && pwmMode && (topSel == TOP_CMPA);
    assign chWr    = wrEn && (wrAddr == ADDR_CMP0 + 3'(ch));
    assign matchEv[ch]   = strobe.tick && (cnt == actQ);
    assign cmpActVec[ch] = actQ;
    assign cmpBufVec[ch] = bufQ;
    assign outVec[ch]    = outQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        bufQ <= '0;
        actQ <= '0;
        outQ <= 1'b0;
      end else begin
        if (chWr) bufQ <= wrData;
        if (chWr && !pwmMode)       actQ <= wrData;
        else if (pwmMode && wrapEv) actQ <= bufQ;
        case (outMode)
          2'd1: if (matchEv[ch]) outQ <= ~outQ;
          2'd2: begin
            if (!pwmMode || blocked) outQ <= 1'b0;
            else if (wrapEv)         outQ <= 1'b1;
            else if (matchEv[ch])    outQ <= 1'b0;
          end
          default: outQ <= 1'b0;
        endcase
      end
    end

    assert_match_flag_R4: assert property (@(posedge clk) disable iff (rst)
      matchEv[ch] |=> flags[ch+1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlA  <= '0;
      ctrlB  <= '0;
      cnt    <= '0;
      capReg <= '0;
      flags  <= '0;
      mask   <= '0;
    end else begin
      if (wrEn && wrAddr == ADDR_CTRLA) ctrlA <= wrData[7:0];
      if (wrEn && wrAddr == ADDR_CTRLB) ctrlB <= wrData[7:0];
      if (wrEn && wrAddr == ADDR_MASK)  mask  <= wrData[FLAG_W-1:0];
      if (cntWr)            cnt <= wrData;
      else if (strobe.tick) cnt <= atTop ? '0 : cnt + 1'b1;
      if (capWr)               capReg <= wrData;
      else if (strobe.capture) capReg <= cnt;
      flags <= (flags & ~clrVec) | setVec;
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_CTRLA:    rdData = CNT_W'(ctrlA);
      ADDR_CTRLB:    rdData = CNT_W'(ctrlB);
      ADDR_CNT:      rdData = cnt;
      ADDR_CMP0:     rdData = cmpBufVec[0];
      ADDR_CMP0 + 1: rdData = cmpBufVec[1];
      ADDR_CAP:      rdData = capReg;
      ADDR_FLAGS:    rdData = CNT_W'(flags);
      default:       rdData = CNT_W'(mask);
    endcase
  end

  assign irq = flags & mask;

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && atTop && !cntWr) |=> (cnt == '0));
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe.tick && atTop) |=> flags[0]);
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!strobe.tick && !cntWr) |=> $stable(cnt));
  assert_capture_copy_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && !capWr) |=> (capReg == $past(cnt)));
endmodule

// File: rtl/timer_cc.sv
module timer_cc
  import timer_cc_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int PRESCALE_DIV = 8,
  parameter int FILT_LEN     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [2:0]        rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              extClk,
  input  logic              capPin,
  input  logic              compIn,
  output logic              outA,
  output logic              outB,
  output logic [FLAG_W-1:0] irq
);
  tmrStrobe_t        strobe;
  clkSel_e           clkSel;
  logic              capRise, capSrc, capFilt;
  logic [NUM_CH-1:0] outVec;

  timer_cc_ctrl #(.PRESCALE_DIV(PRESCALE_DIV), .FILT_LEN(FILT_LEN)) uCtrl (
    .clk(clk), .rst(rst), .clkSel(clkSel), .capRise(capRise), .capSrc(capSrc),
    .capFilt(capFilt), .extClk(extClk), .capPin(capPin), .compIn(compIn),
    .strobe(strobe)
  );

  timer_cc_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .outVec(outVec),
    .irq(irq), .clkSel(clkSel), .capRise(capRise), .capSrc(capSrc),
    .capFilt(capFilt)
  );

  assign outA = outVec[0];
  assign outB = outVec[1];
endmodule

// File: tb/timer_cc_test.sv
`timescale 1ns/1ps
module timer_cc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        extClk = 1'b0, capPin = 1'b0, compIn = 1'b0;
  logic        outA, outB;
  logic [3:0]  irq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [2:0]  addrQ[$];
  logic [15:0] expQ[$];
  bit          pinQ[$];
  string       tagQ[$];

  timer_cc uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extClk(extClk), .capPin(capPin),
    .compIn(compIn), .outA(outA), .outB(outB), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // Monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        logic [2:0]  a;
        logic [15:0] e, got;
        bit          p;
        string       t;
        a = addrQ.pop_front();
        e = expQ.pop_front();
        p = pinQ.pop_front();
        t = tagQ.pop_front();
        rdAddr = a;
        #1;
        got = p ? {10'd0, irq, outB, outA} : rdData;
        checks++;
        if (got !== e) begin
          failures++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", t, got, e);
        end
      end
    end
  end

  task automatic waitSb();
    while (expQ.size() != 0) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic expReg(input logic [2:0] a, input logic [15:0] e, input string t);
    addrQ.push_back(a); expQ.push_back(e); pinQ.push_back(1'b0); tagQ.push_back(t);
    waitSb();
  endtask

  task automatic expPins(input logic [15:0] e, input string t);
    addrQ.push_back(3'd0); expQ.push_back(e); pinQ.push_back(1'b1); tagQ.push_back(t);
    waitSb();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); extClk = 1'b1;
      waitN(3);
      extClk = 1'b0;
      waitN(3);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitN(4);
    rst = 1'b0;
    // R1 reset state
    expReg(3'd2, 16'h0, "R1 count");
    expReg(3'd0, 16'h0, "R1 ctrlA");
    expReg(3'd6, 16'h0, "R1 flags");
    expPins(16'h0, "R1 pins");
    // R2 no source: holds
    pulse(3);
    expReg(3'd2, 16'h0, "R2 stopped");
    // R2 internal divider: 80 clocks -> 10 ticks
    wr(3'd1, 16'h1);
    waitN(80);
    wr(3'd1, 16'h0);
    expReg(3'd2, 16'd10, "R2 internal");
    // R11 count load
    wr(3'd2, 16'h1234);
    expReg(3'd2, 16'h1234, "R11 load");
    // R2 external edges
    wr(3'd1, 16'h2);
    pulse(5);
    expReg(3'd2, 16'h1239, "R2 ext rise");
    wr(3'd1, 16'h3);
    pulse(3);
    expReg(3'd2, 16'h123C, "R2 ext fall");
    // R3 wrap at 0xFFFF
    wr(3'd1, 16'h0);
    wr(3'd2, 16'hFFFE);
    wr(3'd6, 16'hF);
    wr(3'd1, 16'h2);
    pulse(2);
    expReg(3'd2, 16'h0, "R3 wrap max");
    expReg(3'd6, 16'h1, "R3 ovf flag");
    // R10 mask, clear
    wr(3'd7, 16'h1);
    expPins(16'h4, "R10 irq on");
    wr(3'd6, 16'h0);
    expReg(3'd6, 16'h1, "R10 zero write keeps");
    wr(3'd6, 16'h1);
    expReg(3'd6, 16'h0, "R10 clear");
    expPins(16'h0, "R10 irq off");
    wr(3'd7, 16'h0);
    // R3/R4/R5 TOP from cmpA, immediate loads
    wr(3'd1, 16'h0);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'd2);
    wr(3'd0, 16'h10);
    wr(3'd2, 16'h0);
    wr(3'd1, 16'h2);
    pulse(6);
    expReg(3'd2, 16'd1, "R3 top cmpA");
    expReg(3'd6, 16'h7, "R4 match flags");
    expReg(3'd3, 16'd4, "R5 cmpA read");
    // R6 toggle
    wr(3'd0, 16'h15);
    wr(3'd6, 16'hF);
    pulse(4);
    expPins(16'h3, "R6 toggle high");
    pulse(5);
    expPins(16'h0, "R6 toggle low");
    // R5/R7 PWM with TOP from capture register
    wr(3'd1, 16'h0);
    wr(3'd5, 16'd7);
    wr(3'd3, 16'd3);
    wr(3'd4, 16'd5);
    wr(3'd0, 16'h6A);
    wr(3'd2, 16'h0);
    wr(3'd3, 16'd6);
    expReg(3'd3, 16'd6, "R5 buffer read");
    wr(3'd6, 16'hF);
    wr(3'd1, 16'h2);
    pulse(4);
    expReg(3'd6, 16'h2, "R5 old active matches");
    pulse(4);
    expReg(3'd6, 16'h7, "R3 top cap flags");
    expReg(3'd2, 16'h0, "R3 top cap wrap");
    expPins(16'h3, "R7 set at wrap");
    pulse(4);
    expPins(16'h3, "R5 new active used");
    pulse(2);
    expPins(16'h1, "R7 B cleared");
    pulse(1);
    expPins(16'h0, "R7 A cleared");
    // R7 TOP from cmpA blocks output A
    wr(3'd1, 16'h0);
    wr(3'd0, 16'h5A);
    wr(3'd2, 16'h0);
    wr(3'd1, 16'h2);
    pulse(7);
    expPins(16'h2, "R7 A held low");
    expReg(3'd2, 16'h0, "R3 wrap at cmpA");
    // R8 capture
    wr(3'd1, 16'h04);
    wr(3'd2, 16'h0ABC);
    wr(3'd6, 16'hF);
    capPin = 1'b1; waitN(6);
    expReg(3'd5, 16'h0ABC, "R8 capture rise");
    expReg(3'd6, 16'h8, "R8 capture flag");
    wr(3'd2, 16'h0111);
    capPin = 1'b0; waitN(6);
    expReg(3'd5, 16'h0ABC, "R8 wrong edge ignored");
    wr(3'd1, 16'h0C);
    compIn = 1'b1; waitN(6);
    expReg(3'd5, 16'h0111, "R8 comparator source");
    compIn = 1'b0; waitN(6);
    wr(3'd2, 16'h0222);
    capPin = 1'b1; waitN(6);
    capPin = 1'b0; waitN(6);
    expReg(3'd5, 16'h0111, "R8 unselected pin ignored");
    wr(3'd1, 16'h08);
    compIn = 1'b1; waitN(6);
    expReg(3'd5, 16'h0111, "R8 falling select rise ignored");
    compIn = 1'b0; waitN(6);
    expReg(3'd5, 16'h0222, "R8 falling capture");
    // R9 filter
    wr(3'd1, 16'h14);
    wr(3'd2, 16'h0333);
    capPin = 1'b1; waitN(2); capPin = 1'b0; waitN(8);
    expReg(3'd5, 16'h0222, "R9 glitch rejected");
    wr(3'd2, 16'h0444);
    capPin = 1'b1; waitN(10);
    expReg(3'd5, 16'h0444, "R9 held level captured");
    capPin = 1'b0; waitN(10);
    wr(3'd1, 16'h04);
    wr(3'd2, 16'h0555);
    capPin = 1'b1; waitN(2); capPin = 1'b0; waitN(8);
    expReg(3'd5, 16'h0555, "R9 unfiltered glitch captured");
    // R10 irq from capture flag
    wr(3'd7, 16'hF);
    expPins(16'h22, "R10 capture irq");
    wr(3'd6, 16'h8);
    expPins(16'h2, "R10 capture irq cleared");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule